// File: doc/BRIEF.md
# Presence-Detect Byte Reader

This block lets a host read one byte at a time from the small configuration memories that sit on the memory modules of a two-channel memory system. The host writes a single 32-bit command word. The block then runs a random-address byte read on a two-wire serial bus: start, device address with the write flag, byte address, repeated start, device address with the read flag, one data byte, master not-acknowledge, and stop. The result is reported in a 16-bit status word that the host polls.

The seven-bit bus address is formed from a four-bit device type and a three-bit slot number. Code 0xA selects the presence-detect memory. The slot number is channel × 4 + slot, for two channels of four slots each. A command with the write flag set sends the data field to the addressed byte instead of reading.

The serial clock comes from a programmable divider. Each serial bit takes four quarter periods of `QTR_DIV` system clocks. Both bus lines are open drain: the outputs request a low level, and releasing a line lets it float high.

Top module: `spd_cmd_port`

## Requirements
- R1: The command word carries the device type in [31:28], the slot number in [26:24], the byte address in [23:16], the write data in [15:8] and the operation in bit 0 (0 = read, 1 = write). Bit 27 and bits [7:1] do not change the transfer. The bus address byte is {device type, slot, R/W}, sent most significant bit first, with R/W = 0 for the write-direction phases and 1 for the read phase.
- R2: The status word holds read-data-valid in bit 15, bus error in bit 13, busy in bit 12 and the data byte in [7:0]. All other bits read 0, and the whole word is 0 after reset.
- R3: When `cmd_wr` is high and busy is clear, the status word one edge later is busy = 1, with read-data-valid, bus error and data all 0.
- R4: When `cmd_wr` is high while busy is set, the command is dropped. The status word does not change, and the running transfer finishes with its original command.
- R5: A read sends start, address+W, byte address, repeated start and address+R. It then reads eight bits and answers with a not-acknowledge followed by stop. On completion busy = 0, read-data-valid = 1, bus error = 0 and the data field holds the byte read.
- R6: A write sends start, address+W, byte address, the data byte and stop. On completion the status word is 0.
- R7: If any byte the block sends (either address phase, the byte address or the write data) is not acknowledged, the block goes straight to stop. It then reports bus error = 1, read-data-valid = 0, data = 0 and busy = 0.
- R8: Busy clears at the edge P × QTR_DIV + 1 edges after the accepting edge. P is 156 for a read, 116 for a write (acknowledged or refused at the data byte), 44 for a refusal at the first address, 80 for a refusal at the byte address and 120 for a refusal at the read address.
- R9: Both lines are released whenever busy is clear. Inside a byte, the data line changes only while the serial clock is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word (layout in R1) |
| status | output | 16 | Status word (layout in R2) |
| scl_low | output | 1 | Pull serial clock low when 1 |
| sda_low | output | 1 | Pull serial data low when 1 |
| sda_in | input | 1 | Sensed level of the serial data line |

## Verification
Each command has two results that fall due at fixed times. The cleared, busy status is due one edge after the accepting edge. The completion status is due P × QTR_DIV + 1 edges later, where P depends on how far the transfer got. The bench records the cycle of the accepting edge. It checks that busy is still set one quarter bit before the computed completion, and that it has cleared within two edges after it. A scoreboard compares the completion word at the exact cycle busy falls against the expected word queued when the command was issued. Checks on the bus contents (address bytes, byte address, write data) are read from the bench's own memory model once each transfer has finished.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;

    localparam int CMD_W      = 32;
    localparam int STAT_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int TYPE_W     = 4;
    localparam int SLOT_W     = 3;
    localparam int ADDR7_W    = TYPE_W + SLOT_W;
    localparam int TYPE_LSB   = 28;
    localparam int SLOT_LSB   = 24;
    localparam int BADDR_LSB  = 16;
    localparam int WDATA_LSB  = 8;
    localparam int OP_BIT     = 0;
    localparam int ST_RDV_BIT  = 15;
    localparam int ST_ERR_BIT  = 13;
    localparam int ST_BUSY_BIT = 12;
    localparam int BIT_CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [TYPE_W-1:0] dev_type;
        logic [SLOT_W-1:0] slot;
        logic [BYTE_W-1:0] baddr;
        logic [BYTE_W-1:0] wdata;
        logic              is_write;
    } spd_cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_DEVW, ST_WADDR, ST_WDATA,
        ST_RSTART, ST_DEVR, ST_RDATA, ST_STOP
    } spd_step_e;

    typedef struct packed {
        spd_step_e              step;
        logic [1:0]             phase;
        logic [BIT_CNT_W-1:0]   bidx;
        logic [BYTE_W-1:0]      shreg;
        logic                   ack_bad;
        logic                   fail;
        logic                   done;
        logic [BYTE_W-1:0]      rdata;
        logic [ADDR7_W-1:0]     dev7;
        logic [BYTE_W-1:0]      baddr;
        logic [BYTE_W-1:0]      wdata;
        logic                   is_write;
    } spd_seq_t;

    typedef struct packed {
        logic              busy;
        logic              rdv;
        logic              berr;
        logic              was_read;
        logic [BYTE_W-1:0] data;
    } spd_stat_t;

    function automatic logic step_is_byte(spd_step_e s);
        return (s == ST_DEVW) || (s == ST_WADDR) || (s == ST_WDATA) ||
               (s == ST_DEVR) || (s == ST_RDATA);
    endfunction

    function automatic logic step_drives(spd_step_e s);
        return (s == ST_DEVW) || (s == ST_WADDR) || (s == ST_WDATA) ||
               (s == ST_DEVR);
    endfunction

endpackage

// File: rtl/spd_cmd_decode.sv
`timescale 1ns/1ps
module spd_cmd_decode
    import spd_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output spd_cmd_t         cmd
);

    logic spare_unused;

    always_comb begin
        cmd.dev_type = cmd_word[TYPE_LSB  +: TYPE_W];
        cmd.slot     = cmd_word[SLOT_LSB  +: SLOT_W];
        cmd.baddr    = cmd_word[BADDR_LSB +: BYTE_W];
        cmd.wdata    = cmd_word[WDATA_LSB +: BYTE_W];
        cmd.is_write = cmd_word[OP_BIT];
    end

    // Clock-override flag and bits [7:1] carry no transfer meaning here.
    assign spare_unused = ^{cmd_word[SLOT_LSB + SLOT_W], cmd_word[WDATA_LSB-1:OP_BIT+1]};

endmodule

// File: rtl/spd_tick_gen.sv
`timescale 1ns/1ps
module spd_tick_gen #(
    parameter int QTR_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int              CW   = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0]   LAST = CW'(QTR_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tg_t;

    tg_t tg_d, tg_q;

    always_comb begin
        tg_d = tg_q;
        if (!run || (tg_q.cnt == LAST)) begin
            tg_d.cnt = '0;
        end else begin
            tg_d.cnt = tg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '0;
        end else begin
            tg_q <= tg_d;
        end
    end

    assign tick = run && (tg_q.cnt == LAST);

    generate
        if (QTR_DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R8
        end
    endgenerate

endmodule

// File: rtl/spd_bus_seq.sv
`timescale 1ns/1ps
module spd_bus_seq
    import spd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  spd_cmd_t          cmd,
    input  logic              tick,
    input  logic              sda_in,
    output logic              scl_low,
    output logic              sda_low,
    output logic              active,
    output logic              done,
    output logic              fail,
    output logic [BYTE_W-1:0] rdata
);

    localparam logic [BIT_CNT_W-1:0] ACK_IDX = BIT_CNT_W'(BYTE_W);

    spd_seq_t sq_d, sq_q;

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (sq_q.step == ST_IDLE) begin
            if (go) begin
                sq_d.step     = ST_START;
                sq_d.phase    = '0;
                sq_d.bidx     = '0;
                sq_d.ack_bad  = 1'b0;
                sq_d.fail     = 1'b0;
                sq_d.dev7     = {cmd.dev_type, cmd.slot};
                sq_d.baddr    = cmd.baddr;
                sq_d.wdata    = cmd.wdata;
                sq_d.is_write = cmd.is_write;
            end
        end else if (tick) begin
            if (sq_q.phase != 2'd3) begin
                sq_d.phase = sq_q.phase + 2'd1;
                if ((sq_q.phase == 2'd2) && step_is_byte(sq_q.step)) begin
                    if (sq_q.bidx == ACK_IDX) begin
                        sq_d.ack_bad = sda_in;
                    end else if (sq_q.step == ST_RDATA) begin
                        sq_d.shreg = {sq_q.shreg[BYTE_W-2:0], sda_in};
                    end
                end
            end else begin
                sq_d.phase = '0;
                case (sq_q.step)
                    ST_START: begin
                        sq_d.step  = ST_DEVW;
                        sq_d.bidx  = '0;
                        sq_d.shreg = {sq_q.dev7, 1'b0};
                    end
                    ST_RSTART: begin
                        sq_d.step  = ST_DEVR;
                        sq_d.bidx  = '0;
                        sq_d.shreg = {sq_q.dev7, 1'b1};
                    end
                    ST_STOP: begin
                        sq_d.step = ST_IDLE;
                        sq_d.done = 1'b1;
                    end
                    default: begin
                        if (sq_q.bidx != ACK_IDX) begin
                            sq_d.bidx = sq_q.bidx + 1'b1;
                            if (step_drives(sq_q.step)) begin
                                sq_d.shreg = {sq_q.shreg[BYTE_W-2:0], 1'b0};
                            end
                        end else begin
                            sq_d.bidx = '0;
                            if (step_drives(sq_q.step) && sq_q.ack_bad) begin
                                sq_d.fail = 1'b1;
                                sq_d.step = ST_STOP;
                            end else begin
                                case (sq_q.step)
                                    ST_DEVW: begin
                                        sq_d.step  = ST_WADDR;
                                        sq_d.shreg = sq_q.baddr;
                                    end
                                    ST_WADDR: begin
                                        if (sq_q.is_write) begin
                                            sq_d.step  = ST_WDATA;
                                            sq_d.shreg = sq_q.wdata;
                                        end else begin
                                            sq_d.step = ST_RSTART;
                                        end
                                    end
                                    ST_DEVR:  sq_d.step = ST_RDATA;
                                    ST_RDATA: begin
                                        sq_d.rdata = sq_q.shreg;
                                        sq_d.step  = ST_STOP;
                                    end
                                    default:  sq_d.step = ST_STOP;
                                endcase
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q      <= '0;
            sq_q.step <= ST_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    // Line levels per quarter phase of the current step.
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        case (sq_q.step)
            ST_IDLE: begin
                scl_low = 1'b0;
                sda_low = 1'b0;
            end
            ST_START: begin
                scl_low = (sq_q.phase == 2'd3);
                sda_low = (sq_q.phase != 2'd0);
            end
            ST_RSTART: begin
                scl_low = (sq_q.phase == 2'd0) || (sq_q.phase == 2'd3);
                sda_low = (sq_q.phase >= 2'd2);
            end
            ST_STOP: begin
                scl_low = (sq_q.phase == 2'd0);
                sda_low = (sq_q.phase <= 2'd1);
            end
            default: begin
                scl_low = (sq_q.phase == 2'd0) || (sq_q.phase == 2'd3);
                sda_low = step_drives(sq_q.step) && (sq_q.bidx != ACK_IDX) &&
                          !sq_q.shreg[BYTE_W-1];
            end
        endcase
    end

    assign active = (sq_q.step != ST_IDLE);
    assign done   = sq_q.done;
    assign fail   = sq_q.fail;
    assign rdata  = sq_q.rdata;

    AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_is_byte(sq_q.step) && step_is_byte($past(sq_q.step)) && !scl_low && !$past(scl_low))
        |-> (sda_low == $past(sda_low))); // R9

    AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!scl_low && !sda_low)); // R9

endmodule

// File: rtl/spd_cmd_port.sv
`timescale 1ns/1ps
module spd_cmd_port
    import spd_pkg::*;
#(
    parameter int QTR_DIV = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic [STAT_W-1:0] status,
    output logic              scl_low,
    output logic              sda_low,
    input  logic              sda_in
);

    spd_cmd_t           cmd;
    spd_stat_t          st_d, st_q;
    logic               accept;
    logic               tick;
    logic               seq_active;
    logic               seq_done;
    logic               seq_fail;
    logic [BYTE_W-1:0]  seq_rdata;

    spd_cmd_decode u_dec (
        .cmd_word (cmd_word),
        .cmd      (cmd)
    );

    spd_tick_gen #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (seq_active),
        .tick  (tick)
    );

    spd_bus_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (accept),
        .cmd     (cmd),
        .tick    (tick),
        .sda_in  (sda_in),
        .scl_low (scl_low),
        .sda_low (sda_low),
        .active  (seq_active),
        .done    (seq_done),
        .fail    (seq_fail),
        .rdata   (seq_rdata)
    );

    assign accept = cmd_wr && !st_q.busy;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy     = 1'b1;
            st_d.rdv      = 1'b0;
            st_d.berr     = 1'b0;
            st_d.data     = '0;
            st_d.was_read = !cmd.is_write;
        end else if (seq_done) begin
            st_d.busy = 1'b0;
            st_d.berr = seq_fail;
            st_d.rdv  = st_q.was_read && !seq_fail;
            st_d.data = (st_q.was_read && !seq_fail) ? seq_rdata : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status                = '0;
        status[ST_RDV_BIT]    = st_q.rdv;
        status[ST_ERR_BIT]    = st_q.berr;
        status[ST_BUSY_BIT]   = st_q.busy;
        status[BYTE_W-1:0]    = st_q.data;
    end

    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !status[ST_BUSY_BIT]) |=>
        (status[ST_BUSY_BIT] && !status[ST_RDV_BIT] && !status[ST_ERR_BIT])); // R3

    AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_BUSY_BIT] && !seq_done) |=> $stable(status)); // R4

    AST_VALID_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RDV_BIT] |-> (!status[ST_ERR_BIT] && !status[ST_BUSY_BIT])); // R5

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_ERR_BIT] |-> (status[BYTE_W-1:0] == '0)); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !status[ST_BUSY_BIT] |-> (!scl_low && !sda_low)); // R9

endmodule

// File: tb/sim_spd_cmd_port.sv
`timescale 1ns/1ps
module sim_spd_cmd_port;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [15:0] status;
    logic        scl_low_w, sda_low_w;
    logic        s_low = 1'b0;
    logic        scl_line, sda_line;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;

    assign scl_line = ~scl_low_w;
    assign sda_line = ~(sda_low_w | s_low);

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spd_cmd_port #(.QTR_DIV(DIV)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_word (cmd_word),
        .status   (status),
        .scl_low  (scl_low_w),
        .sda_low  (sda_low_w),
        .sda_in   (sda_line)
    );

    // ---------------- memory model on the bus ----------------
    logic [7:0] present = 8'b0010_0101;   // slots 0, 2, 5
    bit         expect_write = 0;
    bit         nack_waddr = 0, nack_wdata = 0, nack_devr = 0;
    logic [7:0] seen_dev = '0, seen_dev_rd = '0, seen_addr = '0, seen_wdata = '0;

    function automatic logic [7:0] ee(input logic [2:0] slot, input logic [7:0] a);
        return 8'(a * 3 + slot * 17 + 8'h5A);
    endfunction

    task automatic wait_start();
        forever begin
            @(negedge sda_line);
            if (scl_line) break;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_line);
            b = {b[6:0], sda_line};
        end
    endtask

    task automatic give_ack();
        @(negedge scl_line);
        s_low = 1'b1;
        @(negedge scl_line);
        s_low = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            s_low = ~v[i];
            @(posedge scl_line);
            @(negedge scl_line);
        end
        s_low = 1'b0;
    endtask

    initial begin
        logic [7:0] b, a, d, b2;
        forever begin
            wait_start();
            recv_byte(b);
            seen_dev = b;
            if (!(b[7:4] == 4'hA && present[b[3:1]] && b[0] == 1'b0)) continue;
            give_ack();
            recv_byte(a);
            seen_addr = a;
            if (nack_waddr) continue;
            give_ack();
            if (expect_write) begin
                recv_byte(d);
                seen_wdata = d;
                if (nack_wdata) continue;
                give_ack();
            end else begin
                wait_start();
                recv_byte(b2);
                seen_dev_rd = b2;
                if (b2 != {b[7:1], 1'b1} || nack_devr) continue;
                give_ack();
                send_byte(ee(b[3:1], a));
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    logic [15:0] exp_q[$];
    string       req_q[$];

    // Monitor: compare the completion word on the cycle busy falls.
    initial begin
        logic prev;
        logic [15:0] e;
        string r;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !status[12]) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2", "completion with nothing queued", status, 0);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(status == e, r, "completion status", status, e);
                end
            end
            prev = status[12];
        end
    end

    function automatic logic [31:0] mk(input logic [3:0] ty, input logic [2:0] slot,
                                       input logic [7:0] ba, input logic [7:0] wd,
                                       input logic wr);
        return {ty, 1'b0, slot, ba, wd, 7'b0, wr};
    endfunction

    task automatic start_cmd(input logic [31:0] w, input logic [15:0] exp,
                             input string req, output int t0);
        while (status[12]) @(negedge clk);
        @(negedge clk);
        cmd_word = w;
        cmd_wr   = 1'b1;
        exp_q.push_back(exp);
        req_q.push_back(req);
        @(negedge clk);
        cmd_wr = 1'b0;
        t0 = cyc;
        check(status == 16'h1000, "R3", "status after accept", status, 16'h1000);
    endtask

    task automatic finish_cmd(input int t0, input int quarters);
        while (cyc < t0 + (quarters - 1) * DIV) @(negedge clk);
        check(status[12] == 1'b1, "R8", "busy before due time", status[12], 1);
        while (cyc < t0 + quarters * DIV + 3) @(negedge clk);
        check(status[12] == 1'b0, "R8", "busy after due time", status[12], 0);
        check({scl_low_w, sda_low_w} == 2'b00, "R9", "lines released when idle",
              {scl_low_w, sda_low_w}, 0);
    endtask

    task automatic run_cmd(input logic [31:0] w, input logic [15:0] exp,
                           input string req, input int quarters);
        int t0;
        start_cmd(w, exp, req, t0);
        finish_cmd(t0, quarters);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        report();
    end

    initial begin
        int t0;
        logic [15:0] snap;
        repeat (4) @(negedge clk);
        check(status == 16'h0000, "R2", "status in reset", status, 0);
        check({scl_low_w, sda_low_w} == 2'b00, "R9", "lines in reset", {scl_low_w, sda_low_w}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(status == 16'h0000, "R2", "status after reset", status, 0);

        // R5 read, channel 0 slot 0
        expect_write = 0;
        run_cmd(mk(4'hA, 3'd0, 8'h10, 8'h00, 1'b0), {8'h80, ee(3'd0, 8'h10)}, "R5", 156);
        check(seen_dev == 8'hA0, "R1", "write-direction address byte", seen_dev, 8'hA0);
        check(seen_dev_rd == 8'hA1, "R1", "read-direction address byte", seen_dev_rd, 8'hA1);
        check(seen_addr == 8'h10, "R1", "byte address on bus", seen_addr, 8'h10);

        // R5 read, channel 1 slot 1 (slot number 5), top byte address
        run_cmd(mk(4'hA, 3'd5, 8'hFF, 8'h00, 1'b0), {8'h80, ee(3'd5, 8'hFF)}, "R5", 156);
        check(seen_dev_rd == 8'hAB, "R1", "slot 5 read address byte", seen_dev_rd, 8'hAB);

        // R1 clock-override bit and bits [7:1] do not change a read
        run_cmd(mk(4'hA, 3'd2, 8'h00, 8'h77, 1'b0) | 32'h0800_00FE,
                {8'h80, ee(3'd2, 8'h00)}, "R1", 156);

        // R6 write
        expect_write = 1;
        run_cmd(mk(4'hA, 3'd2, 8'h33, 8'hC4, 1'b1), 16'h0000, "R6", 116);
        check(seen_wdata == 8'hC4, "R6", "write data on bus", seen_wdata, 8'hC4);
        check(seen_addr == 8'h33, "R6", "write byte address", seen_addr, 8'h33);
        expect_write = 0;

        // R7 absent slot: refused first address
        run_cmd(mk(4'hA, 3'd3, 8'h01, 8'h00, 1'b0), 16'h2000, "R7", 44);
        // R1 wrong device type refused
        run_cmd(mk(4'h5, 3'd0, 8'h01, 8'h00, 1'b0), 16'h2000, "R1", 44);
        check(seen_dev == 8'h50, "R1", "device type in address byte", seen_dev, 8'h50);

        // R7 refusal at byte address
        nack_waddr = 1;
        run_cmd(mk(4'hA, 3'd0, 8'h44, 8'h00, 1'b0), 16'h2000, "R7", 80);
        nack_waddr = 0;

        // R7 refusal at write data
        expect_write = 1;
        nack_wdata = 1;
        run_cmd(mk(4'hA, 3'd0, 8'h45, 8'h99, 1'b1), 16'h2000, "R7", 116);
        nack_wdata = 0;
        expect_write = 0;

        // R7 refusal at read address
        nack_devr = 1;
        run_cmd(mk(4'hA, 3'd5, 8'h46, 8'h00, 1'b0), 16'h2000, "R7", 120);
        nack_devr = 0;

        // R5 read after an error restores normal result
        run_cmd(mk(4'hA, 3'd0, 8'h7F, 8'h00, 1'b0), {8'h80, ee(3'd0, 8'h7F)}, "R5", 156);

        // R4 command while busy is dropped
        start_cmd(mk(4'hA, 3'd5, 8'h21, 8'h00, 1'b0), {8'h80, ee(3'd5, 8'h21)}, "R4", t0);
        repeat (30) @(negedge clk);
        snap = status;
        cmd_word = mk(4'hA, 3'd0, 8'h99, 8'h55, 1'b1);
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        @(negedge clk);
        check(status == snap, "R4", "status after dropped command", status, snap);
        finish_cmd(t0, 156);
        check(seen_addr == 8'h21, "R4", "byte address of original command", seen_addr, 8'h21);
        check(seen_dev_rd == 8'hAB, "R4", "address of original command", seen_dev_rd, 8'hAB);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R2", "all completions seen", exp_q.size(), 0);
        report();
    end

endmodule